// File: doc/BRIEF.md
# Registered Carry-Select Adder

This block adds two unsigned-or-two's-complement words of `WIDTH` bits and returns the sum modulo 2^`WIDTH`. The final carry is dropped. The adder is cut into sections. The lowest section is a plain ripple chain fed by a carry of zero. Every higher section holds two ripple chains that run at the same time, one assuming an incoming carry of 0 and one assuming 1. The carry chosen by the section below then steers a multiplexer that picks the correct partial sum and the correct carry onward. All ripple chains are built from full adders made of AND, OR and XOR gates.

Both operands are captured in registers on the rising clock edge, and the result is also held in a register, so the adder logic sits between two register boundaries. An operand pair applied at the pins appears on the sum output two edges later. A new pair may be applied every cycle.

The `SPLIT` parameter chooses the section layout:
- `SPLIT` = 0 gives two equal halves.
- `SPLIT` = 1 gives three sections of growing width (4, 5 and 7 bits at a width of 16), so each upper section's candidate sums are ready about when its select carry arrives.

Top module: `csa_reg_adder`

## Requirements
- R1: `sum_out` equals (`a_in` + `b_in`) mod 2^`WIDTH`, where `a_in` and `b_in` are the values sampled two rising edges earlier.
- R2: A carry out of the most significant bit is discarded. For example, 16'hFFFF + 16'h0001 gives 16'h0000, and 16'h8000 + 16'h8000 gives 16'h0000.
- R3: While `rst_n` is low, the operand registers and `sum_out` are zero. The reset is asynchronous and active low.
- R4: With `SPLIT` = 0, the adder uses two sections of `WIDTH`/2 bits each, and sums whose carry crosses bit `WIDTH`/2 are correct (for example 16'h00FF + 16'h0001 = 16'h0100).
- R5: With `SPLIT` = 1, the adder uses three sections, low to high:
  - `WIDTH`/4 bits;
  - (5·`WIDTH`)/16 bits;
  - the remaining bits.

  At a width of 16 these are 4, 5 and 7 bits, and carries crossing bits 4 and 9 give correct sums (16'h000F + 1 = 16'h0010, 16'h01FF + 1 = 16'h0200).
- R6: The carry entering each section, and the carry out of the top section, equal the carry of the true sum of the registered operand bits below that section's base.
- R7: One operand pair is accepted on every clock edge. Back-to-back pairs produce a result stream in the same order with no gaps, and `sum_out` holds steady while the registered operands do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | WIDTH | First operand |
| b_in | input | WIDTH | Second operand |
| sum_out | output | WIDTH | Registered sum modulo 2^WIDTH |

## Verification
The bench builds four instances side by side:
- `WIDTH` = 16 with both `SPLIT` values;
- `WIDTH` = 8 with both `SPLIT` values, which gives section layouts of 2/2/4 and 4/4.

At width 8 the bench drives all 65,536 operand pairs, one per clock. This covers every carry pattern across every section boundary and both select values of each multiplexer.

The 16-bit instances get the same clock stream. They see directed vectors first:
- all ones plus one;
- the most negative value doubled;
- carries stopping exactly at bits 4, 8 and 9.

After those come pseudo-random pairs. Each result is compared with an arithmetic sum computed in the bench.

// File: rtl/csa_pkg.sv
package csa_pkg;

   // number of sections for a split mode
   function automatic int sec_count(input int mode);
      return (mode == 0) ? 2 : 3;
   endfunction

   // width of section idx (0 = least significant)
   function automatic int sec_width(input int width, input int mode, input int idx);
      int w0;
      int w1;
      if (mode == 0) begin
         return width / 2;
      end
      w0 = width / 4;
      w1 = (width * 5) / 16;
      if (idx == 0) return w0;
      if (idx == 1) return w1;
      return width - w0 - w1;
   endfunction

   // lowest bit position of section idx
   function automatic int sec_base(input int width, input int mode, input int idx);
      int acc;
      acc = 0;
      for (int k = 0; k < idx; k++) acc += sec_width(width, mode, k);
      return acc;
   endfunction

endpackage

// File: rtl/csa_full_add.sv
module csa_full_add (
   input  logic a,
   input  logic b,
   input  logic ci,
   output logic s,
   output logic co
);
   logic p;

   assign p  = a ^ b;
   assign s  = p ^ ci;
   assign co = (a & b) | (ci & p);
endmodule

// File: rtl/csa_ripple.sv
module csa_ripple #(
   parameter int W = 4
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout
);
   logic [W:0] c;

   assign c[0] = cin;

   for (genvar i = 0; i < W; i++) begin : g_bit
      csa_full_add u_fa (
         .a  (a[i]),
         .b  (b[i]),
         .ci (c[i]),
         .s  (sum[i]),
         .co (c[i+1])
      );
   end

   assign cout = c[W];
endmodule

// File: rtl/csa_section.sv
module csa_section #(
   parameter int W     = 4,
   parameter bit FIRST = 1'b0
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout
);
   if (FIRST) begin : g_plain
      // lowest section: single chain driven straight from the incoming carry
      csa_ripple #(.W(W)) u_rip (
         .a    (a),
         .b    (b),
         .cin  (cin),
         .sum  (sum),
         .cout (cout)
      );
   end else begin : g_dual
      logic [W-1:0] sum_c0;
      logic [W-1:0] sum_c1;
      logic         co_c0;
      logic         co_c1;

      csa_ripple #(.W(W)) u_rip0 (
         .a    (a),
         .b    (b),
         .cin  (1'b0),
         .sum  (sum_c0),
         .cout (co_c0)
      );

      csa_ripple #(.W(W)) u_rip1 (
         .a    (a),
         .b    (b),
         .cin  (1'b1),
         .sum  (sum_c1),
         .cout (co_c1)
      );

      // the chosen carry from below steers both the sum and the carry onward
      assign sum  = cin ? sum_c1 : sum_c0;
      assign cout = cin ? co_c1  : co_c0;
   end
endmodule

// File: rtl/csa_reg_adder.sv
module csa_reg_adder
   import csa_pkg::*;
#(
   parameter int WIDTH = 16,
   parameter int SPLIT = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] sum_out
);
   localparam int NSEC = sec_count(SPLIT);

   // elaboration-time parameter checks
   if (SPLIT != 0 && SPLIT != 1) begin : g_bad_split
      $error("csa_reg_adder: SPLIT must be 0 or 1");
   end
   if (SPLIT == 0 && (WIDTH % 2) != 0) begin : g_bad_even
      $error("csa_reg_adder: two-way split needs an even WIDTH");
   end
   if (WIDTH < 4) begin : g_bad_width
      $error("csa_reg_adder: WIDTH must be at least 4");
   end

   logic [WIDTH-1:0] a_q;
   logic [WIDTH-1:0] b_q;
   logic [WIDTH-1:0] sum_c;
   logic [NSEC:0]    carry;

   assign carry[0] = 1'b0;

   for (genvar k = 0; k < NSEC; k++) begin : g_sec
      localparam int SW = sec_width(WIDTH, SPLIT, k);
      localparam int SB = sec_base(WIDTH, SPLIT, k);

      csa_section #(.W(SW), .FIRST(k == 0)) u_sec (
         .a    (a_q[SB +: SW]),
         .b    (b_q[SB +: SW]),
         .cin  (carry[k]),
         .sum  (sum_c[SB +: SW]),
         .cout (carry[k+1])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q     <= '0;
         b_q     <= '0;
         sum_out <= '0;
      end else begin
         a_q     <= a_in;
         b_q     <= b_in;
         sum_out <= sum_c;
      end
   end
endmodule

// File: rtl/csa_reg_adder_chk.sv
module csa_reg_adder_chk
   import csa_pkg::*;
#(
   parameter int WIDTH = 16,
   parameter int SPLIT = 1
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [WIDTH-1:0]         a_in,
   input logic [WIDTH-1:0]         b_in,
   input logic [WIDTH-1:0]         a_q,
   input logic [WIDTH-1:0]         b_q,
   input logic [WIDTH-1:0]         sum_out,
   input logic [sec_count(SPLIT):0] carry
);
   localparam int NSEC = sec_count(SPLIT);

   logic [1:0] since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               since_rst <= 2'd0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   // R1 / R2: two-edge latency, sum modulo 2^WIDTH
   assert_sum_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2'd2) |-> (sum_out == WIDTH'($past(a_in, 2) + $past(b_in, 2))));

   // R3: cleared state while reset is held
   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_clear_R3: assert (sum_out == '0 && a_q == '0 && b_q == '0);
      end
   end

   // R7: unchanged registered operands keep the result steady
   assert_hold_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2'd1 && a_q == $past(a_q) && b_q == $past(b_q)) |=> $stable(sum_out));

   // R6: each select carry and the top carry match the true low-order carry
   for (genvar k = 1; k <= NSEC; k++) begin : g_cchk
      localparam int            BB = sec_base(WIDTH, SPLIT, k);
      localparam logic [WIDTH:0] MK = (WIDTH+1)'((64'd1 << BB) - 64'd1);
      logic [WIDTH:0] low_sum;

      assign low_sum = ({1'b0, a_q} & MK) + ({1'b0, b_q} & MK);

      assert_select_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
         carry[k] == low_sum[BB]);
   end
endmodule

bind csa_reg_adder csa_reg_adder_chk #(.WIDTH(WIDTH), .SPLIT(SPLIT)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .a_in    (a_in),
   .b_in    (b_in),
   .a_q     (a_q),
   .b_q     (b_q),
   .sum_out (sum_out),
   .carry   (carry)
);

// File: tb/sim_csa_reg_adder.sv
module sim_csa_reg_adder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] a16 = '0;
   logic [15:0] b16 = '0;
   logic [7:0]  a8 = '0;
   logic [7:0]  b8 = '0;
   logic [15:0] s16_3;
   logic [15:0] s16_2;
   logic [7:0]  s8_3;
   logic [7:0]  s8_2;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   csa_reg_adder #(.WIDTH(16), .SPLIT(1)) u0 (.clk(clk), .rst_n(rst_n), .a_in(a16), .b_in(b16), .sum_out(s16_3));
   csa_reg_adder #(.WIDTH(16), .SPLIT(0)) u1 (.clk(clk), .rst_n(rst_n), .a_in(a16), .b_in(b16), .sum_out(s16_2));
   csa_reg_adder #(.WIDTH(8),  .SPLIT(1)) u2 (.clk(clk), .rst_n(rst_n), .a_in(a8),  .b_in(b8),  .sum_out(s8_3));
   csa_reg_adder #(.WIDTH(8),  .SPLIT(0)) u3 (.clk(clk), .rst_n(rst_n), .a_in(a8),  .b_in(b8),  .sum_out(s8_2));

   localparam int NDIR = 16;

   function automatic logic [31:0] dir_vec(input int i);
      case (i)
         0:  return {16'hFFFF, 16'h0001};
         1:  return {16'h8000, 16'h8000};
         2:  return {16'h000F, 16'h0001};
         3:  return {16'h01FF, 16'h0001};
         4:  return {16'h00FF, 16'h0001};
         5:  return {16'h7FFF, 16'h0001};
         6:  return {16'hFFFF, 16'hFFFF};
         7:  return {16'h1234, 16'h4321};
         8:  return {16'h0000, 16'h0000};
         9:  return {16'hAAAA, 16'h5555};
         10: return {16'h5555, 16'h5555};
         11: return {16'h8001, 16'h7FFF};
         12: return {16'h0F0F, 16'hF0F1};
         13: return {16'h0008, 16'h0008};
         14: return {16'h0100, 16'h0100};
         default: return {16'hFE00, 16'h0200};
      endcase
   endfunction

   function automatic string dir_tag(input int i);
      case (i)
         0, 1, 6, 15: return "R2";
         2, 3, 13:    return "R6";
         4, 14:       return "R4";
         default:     return "R1";
      endcase
   endfunction

   task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   initial begin
      logic [15:0] e16_q [2];
      logic [7:0]  e8_q  [2];
      string       t16_q [2];
      bit          v_q   [2];
      logic [31:0] lcg;
      logic [31:0] dv;
      logic [15:0] na;
      logic [15:0] nb;
      string       tg;

      v_q[0] = 1'b0;
      v_q[1] = 1'b0;
      lcg = 32'h1357_9BDF;

      // reset with junk on the operand pins
      a16 = 16'hBEEF; b16 = 16'h1234; a8 = 8'hA5; b8 = 8'h5A;
      repeat (3) @(negedge clk);
      check16("R3", s16_3, 16'h0000);
      check16("R3", s16_2, 16'h0000);
      check8 ("R3", s8_3,  8'h00);
      check8 ("R3", s8_2,  8'h00);
      rst_n = 1'b1;

      for (int i = 0; i < 65536 + 2; i++) begin
         // compare the pair driven two negedges ago
         if (v_q[1]) begin
            check16({"R5/", t16_q[1]}, s16_3, e16_q[1]);
            check16({"R4/", t16_q[1]}, s16_2, e16_q[1]);
            check8 ("R5/R6 exhaustive", s8_3, e8_q[1]);
            check8 ("R4/R6 exhaustive", s8_2, e8_q[1]);
         end
         if (i < NDIR) begin
            dv = dir_vec(i);
            na = dv[31:16];
            nb = dv[15:0];
            tg = dir_tag(i);
         end else begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            na  = lcg[31:16];
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            nb  = lcg[31:16];
            tg  = "R7";
         end
         e16_q[1] = e16_q[0];
         e8_q[1]  = e8_q[0];
         t16_q[1] = t16_q[0];
         v_q[1]   = v_q[0];
         e16_q[0] = na + nb;
         e8_q[0]  = 8'(i[15:8] + i[7:0]);
         t16_q[0] = tg;
         v_q[0]   = (i < 65536);
         a16 = na;
         b16 = nb;
         a8  = i[15:8];
         b8  = i[7:0];
         @(negedge clk);
      end

      // R7: operands held constant keep the output constant
      a16 = 16'h4000; b16 = 16'h4000; a8 = 8'h40; b8 = 8'h40;
      repeat (3) @(negedge clk);
      check16("R7", s16_3, 16'h8000);
      @(negedge clk);
      check16("R7", s16_3, 16'h8000);
      check8 ("R7", s8_2,  8'h80);

      // R3: asynchronous reset clears output mid-stream
      rst_n = 1'b0;
      #1;
      check16("R3", s16_3, 16'h0000);
      check8 ("R3", s8_3,  8'h00);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(5.0 * 190000);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule